// File: doc/BRIEF.md
# Cascadable Six-Bit Universal Counter Slice

This block is one slice of a synchronous up/down counter. It has a parallel load and two active-low carry outputs, so that any number of slices on one clock can be chained into a wide counter without extra gates. A two-bit select picks one of four operations on each rising clock edge: load the data input, count down, count up, or hold. A slice steps only while its carry input is low. An asynchronous master reset clears the count and releases both carry outputs.

Each slice drives two carry signals. `cout_n` is a flip-flop output and is low while this slice and every slice below it sit at the terminal count: 63 when counting up, 0 when counting down. `clout_n` goes low one clock earlier, which means it shows the value that `cout_n` will take at the next edge. It is built from registered look-ahead flags, gated by the incoming `clin_n` and the live select. In a chain, the lowest slice ties `cin_n` and `clin_n` low. Every higher slice takes `cin_n` from the `cout_n` of the slice below and `clin_n` from that slice's `clout_n`.

The carry flip-flop is a two-state machine with states CY_IDLE and CY_ACTIVE. It has four named transitions. ARM goes from CY_IDLE to CY_ACTIVE on a count edge where the look-ahead is asserted. RELEASE goes from CY_ACTIVE to CY_IDLE on a count edge where the look-ahead is clear. CLEAR forces CY_IDLE on a load edge. KEEP leaves the state unchanged on a hold edge. Because a load always passes through CLEAR, loading the terminal value produces no carry on the first count edge that follows.

Top module: `ucnt_slice`

## Requirements
- R1: While `mrst` is high, `q` is 0, `cout_n` is 1, and `clout_n` is 1 under select 11.
- R2: Select 00 (load) sets `q` to `din` at the edge, whatever the value of `cin_n`.
- R3: Select 10 (up) adds one modulo 64 at the edge when `cin_n` is 0, so 63 wraps to 0. When `cin_n` is 1, `q` is kept.
- R4: Select 01 (down) subtracts one modulo 64 at the edge when `cin_n` is 0, so 0 wraps to 63. When `cin_n` is 1, `q` is kept.
- R5: Select 11 (hold) keeps both `q` and `cout_n` unchanged across the edge.
- R6: Under select 10 or 01, `clout_n` is 0 exactly when `clin_n` is 0 and the count after the coming edge will be the terminal value (63 up, 0 down). Under select 00 or 11, or when `clin_n` is 1, `clout_n` is 1.
- R7: After an edge under select 10 or 01, `cout_n` equals the value `clout_n` had just before that edge.
- R8: After a load edge, `cout_n` is 1. A terminal value loaded into the lowest slice therefore wraps on the first count edge with no carry to the slices above it.
- R9: Four slices chained as described form a 24-bit counter. Apart from the R8 case, it follows plus one or minus one across every slice boundary, and stops under hold.
- R10: Raising `mrst` clears `q` and releases `cout_n` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| mrst | input | 1 | Asynchronous master reset, active high |
| sel | input | 2 | Operation: 00 load, 01 down, 10 up, 11 hold |
| din | input | W (6) | Parallel load value |
| cin_n | input | 1 | Count enable from the slice below, active low |
| clin_n | input | 1 | Look-ahead carry from the slice below, active low |
| q | output | W (6) | Current count |
| cout_n | output | 1 | Registered carry out, active low |
| clout_n | output | 1 | Look-ahead carry out, active low, one clock ahead of cout_n |

## Verification
The assertions check on every cycle the local rules of a single slice. These are the load value, the plus and minus one steps and their stall when `cin_n` is high, the hold of count and carry, the quiet look-ahead outside counting, and the rule that `cout_n` takes the previous `clout_n`. Two things only the scenarios can show. The first is that a chain of four slices wired through its carries really counts as one 24-bit number across the 63-to-0 and 0-to-63 boundaries of every slice. The second is that the missing carry after loading a terminal value lands exactly where the R8 arithmetic predicts. The asynchronous clear is also observed in the bench between clock edges.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

    // Operation code, as driven on the select pins
    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_DOWN = 2'b01,
        OP_UP   = 2'b10,
        OP_HOLD = 2'b11
    } op_e;

    // State of the registered carry output
    typedef enum logic {
        CY_IDLE   = 1'b0,
        CY_ACTIVE = 1'b1
    } carry_e;

    // Registered decode of the count, taken from the next-state value
    typedef struct packed {
        logic at_top;    // count is all ones
        logic near_top;  // count is all ones minus one
        logic at_bot;    // count is zero
        logic near_bot;  // count is one
    } edge_flags_t;

endpackage

// File: rtl/ucnt_mode_dec.sv
module ucnt_mode_dec
    import ucnt_pkg::*;
(
    input  logic [1:0] sel,
    output op_e        op,
    output logic       is_count,
    output logic       is_up
);

    always_comb begin
        op       = op_e'(sel);
        is_count = 1'b0;
        is_up    = 1'b0;
        unique case (op)
            OP_LOAD: begin
                is_count = 1'b0;
                is_up    = 1'b0;
            end
            OP_DOWN: begin
                is_count = 1'b1;
                is_up    = 1'b0;
            end
            OP_UP: begin
                is_count = 1'b1;
                is_up    = 1'b1;
            end
            OP_HOLD: begin
                is_count = 1'b0;
                is_up    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ucnt_count_reg.sv
module ucnt_count_reg
    import ucnt_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         mrst,
    input  op_e          op,
    input  logic         cin_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output edge_flags_t  flags
);

    localparam logic [W-1:0] TOP      = {W{1'b1}};
    localparam logic [W-1:0] ONE      = W'(1);
    localparam logic [W-1:0] NEAR_TOP = TOP - ONE;

    logic [W-1:0] q_nxt;
    edge_flags_t  flags_nxt;

    // Next count for each operation
    always_comb begin
        q_nxt = q;
        unique case (op)
            OP_LOAD: q_nxt = din;
            OP_UP:   q_nxt = cin_n ? q : q + ONE;
            OP_DOWN: q_nxt = cin_n ? q : q - ONE;
            OP_HOLD: q_nxt = q;
        endcase
    end

    // Look-ahead decode of the next value, so that the carry path
    // starts from flip-flops rather than from a wide compare
    always_comb begin
        flags_nxt.at_top   = (q_nxt == TOP);
        flags_nxt.near_top = (q_nxt == NEAR_TOP);
        flags_nxt.at_bot   = (q_nxt == '0);
        flags_nxt.near_bot = (q_nxt == ONE);
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            q     <= '0;
            flags <= '{at_top: 1'b0, near_top: 1'b0, at_bot: 1'b1, near_bot: 1'b0};
        end else begin
            q     <= q_nxt;
            flags <= flags_nxt;
        end
    end

endmodule

// File: rtl/ucnt_carry_fsm.sv
module ucnt_carry_fsm
    import ucnt_pkg::*;
(
    input  logic        clk,
    input  logic        mrst,
    input  op_e         op,
    input  logic        is_count,
    input  logic        is_up,
    input  logic        cin_n,
    input  logic        clin_n,
    input  edge_flags_t flags,
    output logic        cout_n,
    output logic        clout_n
);

    carry_e state;
    carry_e state_nxt;
    logic   term_next;
    logic   look;

    // Will the count after the coming edge be terminal, and is the chain below terminal then?
    always_comb begin
        if (is_up) begin
            term_next = cin_n ? flags.at_top : flags.near_top;
        end else begin
            term_next = cin_n ? flags.at_bot : flags.near_bot;
        end
        look = is_count & ~clin_n & term_next;
    end

    // Transitions: ARM, RELEASE, CLEAR, KEEP
    always_comb begin
        state_nxt = state;
        unique case (op)
            OP_LOAD: state_nxt = CY_IDLE;
            OP_HOLD: state_nxt = state;
            OP_UP,
            OP_DOWN: state_nxt = look ? CY_ACTIVE : CY_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            state <= CY_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        cout_n  = (state != CY_ACTIVE);
        clout_n = ~look;
    end

endmodule

// File: rtl/ucnt_slice.sv
module ucnt_slice
    import ucnt_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         mrst,
    input  logic [1:0]   sel,
    input  logic [W-1:0] din,
    input  logic         cin_n,
    input  logic         clin_n,
    output logic [W-1:0] q,
    output logic         cout_n,
    output logic         clout_n
);

    op_e         op;
    logic        is_count;
    logic        is_up;
    edge_flags_t flags;

    ucnt_mode_dec u_dec (
        .sel      (sel),
        .op       (op),
        .is_count (is_count),
        .is_up    (is_up)
    );

    ucnt_count_reg #(.W(W)) u_cnt (
        .clk   (clk),
        .mrst  (mrst),
        .op    (op),
        .cin_n (cin_n),
        .din   (din),
        .q     (q),
        .flags (flags)
    );

    ucnt_carry_fsm u_cy (
        .clk      (clk),
        .mrst     (mrst),
        .op       (op),
        .is_count (is_count),
        .is_up    (is_up),
        .cin_n    (cin_n),
        .clin_n   (clin_n),
        .flags    (flags),
        .cout_n   (cout_n),
        .clout_n  (clout_n)
    );

endmodule

// File: rtl/ucnt_slice_chk.sv
module ucnt_slice_chk #(
    parameter int W = 6
) (
    input logic         clk,
    input logic         mrst,
    input logic [1:0]   sel,
    input logic [W-1:0] din,
    input logic         cin_n,
    input logic         clin_n,
    input logic [W-1:0] q,
    input logic         cout_n,
    input logic         clout_n
);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (mrst)
        sel == 2'b00 |=> q == $past(din));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (mrst)
        (sel == 2'b10 && !cin_n) |=> q == W'($past(q) + 1'b1));

    // R3
    up_stall_chk: assert property (@(posedge clk) disable iff (mrst)
        (sel == 2'b10 && cin_n) |=> $stable(q));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (mrst)
        (sel == 2'b01 && !cin_n) |=> q == W'($past(q) - 1'b1));

    // R4
    down_stall_chk: assert property (@(posedge clk) disable iff (mrst)
        (sel == 2'b01 && cin_n) |=> $stable(q));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (mrst)
        sel == 2'b11 |=> ($stable(q) && $stable(cout_n)));

    // R6
    clout_quiet_chk: assert property (@(posedge clk) disable iff (mrst)
        (sel == 2'b00 || sel == 2'b11 || clin_n) |-> clout_n);

    // R7
    cout_follow_chk: assert property (@(posedge clk) disable iff (mrst)
        (sel == 2'b10 || sel == 2'b01) |=> cout_n == $past(clout_n));

    // R8
    load_release_chk: assert property (@(posedge clk) disable iff (mrst)
        sel == 2'b00 |=> cout_n);

endmodule

bind ucnt_slice ucnt_slice_chk #(.W(W)) u_ucnt_slice_chk (
    .clk     (clk),
    .mrst    (mrst),
    .sel     (sel),
    .din     (din),
    .cin_n   (cin_n),
    .clin_n  (clin_n),
    .q       (q),
    .cout_n  (cout_n),
    .clout_n (clout_n)
);

// File: tb/ucnt_slice_bench.sv
`timescale 1ns/1ps
module ucnt_slice_bench;

    localparam logic [1:0] S_LOAD = 2'b00;
    localparam logic [1:0] S_DOWN = 2'b01;
    localparam logic [1:0] S_UP   = 2'b10;
    localparam logic [1:0] S_HOLD = 2'b11;

    logic clk = 1'b0;
    logic mrst = 1'b1;
    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // single slice under direct control
    logic [1:0] s_sel  = S_HOLD;
    logic [5:0] s_din  = '0;
    logic       s_cin  = 1'b0;
    logic       s_clin = 1'b0;
    logic [5:0] s_q;
    logic       s_cout;
    logic       s_clout;

    ucnt_slice #(.W(6)) u_ucnt_slice (
        .clk (clk), .mrst (mrst), .sel (s_sel), .din (s_din),
        .cin_n (s_cin), .clin_n (s_clin),
        .q (s_q), .cout_n (s_cout), .clout_n (s_clout)
    );

    // four slices chained into 24 bits
    logic [1:0]       c_sel = S_HOLD;
    logic [23:0]      c_din = '0;
    logic [3:0][5:0]  c_qa;
    logic [4:0]       c_cy;
    logic [4:0]       c_la;
    logic [23:0]      c_q;
    assign c_cy[0] = 1'b0;
    assign c_la[0] = 1'b0;
    assign c_q     = c_qa;

    for (genvar i = 0; i < 4; i++) begin : g_chain
        ucnt_slice #(.W(6)) u_link (
            .clk (clk), .mrst (mrst), .sel (c_sel), .din (c_din[6*i +: 6]),
            .cin_n (c_cy[i]), .clin_n (c_la[i]),
            .q (c_qa[i]), .cout_n (c_cy[i+1]), .clout_n (c_la[i+1])
        );
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // chain reference
    logic [23:0] ref24 = '0;
    bit          first = 1'b1;

    task automatic chain_run(input logic [1:0] op, input int n);
        c_sel = op;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            unique case (op)
                S_LOAD: begin ref24 = c_din; first = 1'b1; end
                S_UP: begin
                    if (first && ref24[5:0] == 6'h3F) ref24 = {ref24[23:6], 6'h00};
                    else ref24 = ref24 + 24'd1;
                    first = 1'b0;
                end
                S_DOWN: begin
                    if (first && ref24[5:0] == 6'h00) ref24 = {ref24[23:6], 6'h3F};
                    else ref24 = ref24 - 24'd1;
                    first = 1'b0;
                end
                S_HOLD: ref24 = ref24;
            endcase
            #2;
            chk(c_q == ref24, "R9", int'(c_q), int'(ref24));
        end
    endtask

    task automatic chain_load(input logic [23:0] v);
        c_din = v;
        chain_run(S_LOAD, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int e;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk(s_q == 6'd0, "R1", s_q, 0);
        chk(s_cout == 1'b1, "R1", s_cout, 1);
        chk(s_clout == 1'b1, "R1", s_clout, 1);
        chk(c_q == 24'd0, "R1", int'(c_q), 0);
        mrst = 1'b0;

        // R2 load ignores cin_n
        s_sel = S_LOAD; s_din = 6'h2A; s_cin = 1'b1;
        tick();
        chk(s_q == 6'h2A, "R2", s_q, 6'h2A);
        chk(s_cout == 1'b1, "R8", s_cout, 1);

        // R3 R6 R7 full up sweep from 0
        s_din = 6'h00; tick();
        s_sel = S_UP; s_cin = 1'b0; s_clin = 1'b0;
        e = 0;
        for (int k = 0; k < 130; k++) begin
            #1;
            chk(s_clout == !(((e + 1) & 63) == 63), "R6", s_clout, !(((e + 1) & 63) == 63));
            tick();
            e = (e + 1) & 63;
            chk(s_q == 6'(e), "R3", s_q, e);
            chk(s_cout == !(e == 63), "R7", s_cout, !(e == 63));
        end

        // R6 clin_n high blocks the look-ahead
        s_sel = S_LOAD; s_din = 6'h3E; tick();
        s_sel = S_UP; s_clin = 1'b1; #1;
        chk(s_clout == 1'b1, "R6", s_clout, 1);
        s_clin = 1'b0; #1;
        chk(s_clout == 1'b0, "R6", s_clout, 0);

        // R8 loading terminal gives no carry; R3 stall with cin_n high
        s_sel = S_LOAD; s_din = 6'h3F; tick();
        chk(s_cout == 1'b1, "R8", s_cout, 1);
        s_sel = S_UP; s_cin = 1'b1; #1;
        chk(s_clout == 1'b0, "R6", s_clout, 0);
        tick();
        chk(s_q == 6'h3F, "R3", s_q, 6'h3F);
        chk(s_cout == 1'b0, "R7", s_cout, 0);

        // R5 hold keeps count and carry
        s_sel = S_HOLD; #1;
        chk(s_clout == 1'b1, "R6", s_clout, 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(s_q == 6'h3F, "R5", s_q, 6'h3F);
            chk(s_cout == 1'b0, "R5", s_cout, 0);
        end
        s_sel = S_UP; s_cin = 1'b0; tick();
        chk(s_q == 6'h00, "R3", s_q, 0);
        chk(s_cout == 1'b1, "R7", s_cout, 1);

        // R4 down sweep through the 0 to 63 wrap
        s_sel = S_LOAD; s_din = 6'h05; tick();
        s_sel = S_DOWN;
        e = 5;
        for (int k = 0; k < 70; k++) begin
            #1;
            chk(s_clout == !(((e - 1) & 63) == 0), "R6", s_clout, !(((e - 1) & 63) == 0));
            tick();
            e = (e - 1) & 63;
            chk(s_q == 6'(e), "R4", s_q, e);
            chk(s_cout == !(e == 0), "R7", s_cout, !(e == 0));
        end

        // R10 asynchronous clear between edges
        s_sel = S_LOAD; s_din = 6'h3F; tick();
        s_sel = S_UP; s_cin = 1'b1; tick();
        chk(s_cout == 1'b0, "R7", s_cout, 0);
        #1 mrst = 1'b1;
        #1;
        chk(s_q == 6'd0, "R10", s_q, 0);
        chk(s_cout == 1'b1, "R10", s_cout, 1);
        tick();
        mrst = 1'b0;
        s_sel = S_HOLD; s_cin = 1'b0;
        first = 1'b1; ref24 = '0;

        // R9 chained counting across slice boundaries
        chain_load(24'hFFFFF0);
        chain_run(S_UP, 40);
        chain_run(S_HOLD, 5);
        chain_run(S_UP, 10);
        chain_load(24'h03FFF8);
        chain_run(S_UP, 20);
        chain_load(24'h000010);
        chain_run(S_DOWN, 40);
        chain_load(24'hFC0005);
        chain_run(S_DOWN, 12);
        chain_run(S_HOLD, 4);
        chain_run(S_DOWN, 8);

        // R8 terminal value loaded into the lowest slice
        chain_load(24'h123FFF);
        chain_run(S_UP, 1);
        chk(c_q == 24'h123FC0, "R8", int'(c_q), 24'h123FC0);
        chain_run(S_UP, 70);
        chain_load(24'h000000);
        chain_run(S_DOWN, 1);
        chk(c_q == 24'h00003F, "R8", int'(c_q), 24'h00003F);
        chain_run(S_DOWN, 10);

        // long up run crossing into the third slice
        chain_load(24'h000F00);
        chain_run(S_UP, 4500);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule